// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Deep Status Buffer

This block receives asynchronous serial characters on a single input line. The line passes through a two-flop synchronizer. A programmable divider turns the system clock into oversampling ticks, with 16 ticks per bit in normal mode and 8 in double-speed mode. A small state machine detects the start bit and votes on three samples near the middle of each bit. It assembles characters of 5 to 9 data bits, sent least significant bit first, with optional even or odd parity and one stop bit.

Each finished character goes into a two-entry first-in first-out buffer. Every entry carries its own frame-error, parity-error and data-lost flags. A third finished character waits in a holding register. If another start bit arrives while that holding register and both buffer entries are occupied, the waiting character is marked as lost. An address-filtering mode drops frames whose marker bit is clear. Three interrupt request outputs are registered: receive-complete, transmit-buffer-empty and transmit-done. Each one is the AND of its own enable, a global enable and the matching status flag.

Software or a bus wrapper reads the oldest character from the `rd_*` outputs while `rx_avail` is high, and pops it with a one-cycle `rd_stb`.

Top module: `uart_rx_core`

## Requirements
- R1: A frame is one low start bit, `data_bits` data bits sent least significant bit first, an optional parity bit and one stop bit. `data_bits` values below 5 act as 5 and values above 9 act as 9. The character appears right-aligned on `rd_data` with its unused upper bits zero, so the ninth data bit of a 9-bit character is `rd_data[8]`.
- R2: One oversampling tick occurs every `baud_div`+1 clocks. With `dbl_speed`=0 a bit lasts 16 ticks and is decided by a majority of samples 7, 8 and 9, counted from sample 0 at the start edge. With `dbl_speed`=1 a bit lasts 8 ticks and the vote uses samples 4, 5 and 6. The mode, the character length and the parity mode are taken at the start bit.
- R3: A start requires a high-to-low transition after the line has been seen high. A low pulse shorter than half a bit time yields no character.
- R4: `rd_fe` is 1 when the stop bit of the oldest character was sampled as 0, and 0 when it was sampled as 1.
- R5: The `parity_mode` codes are 2'b10 for even parity, 2'b11 for odd parity, and 2'b00 or 2'b01 for no parity bit. `rd_pe` is 1 only when parity was enabled for that character and the received parity bit did not match the data.
- R6: The buffer holds up to two characters. `rx_avail` is high while at least one unread character is held. `rd_stb` pops the oldest character, and characters come out in arrival order, each with its own flags.
- R7: A data-lost condition arises when both entries are full, a character is waiting in the holding register and a new start bit is detected. The next character to complete replaces the waiting one and carries `rd_dor`=1 when it reaches the head of the buffer.
- R8: With `mpcm_en`=1, a frame whose most significant data bit is 0 is dropped and never reaches the buffer. For 9-bit frames that bit is the ninth bit. Frames with the bit set are stored as usual.
- R9: While `rx_en` is 0, the buffer, the holding register and the data-lost state are cleared, so `rx_avail` is 0 from the next clock.
- R10: `irq_rxc`, `irq_udre` and `irq_txc` are registered. Each is 1 one clock after its own enable (`ie_rxc`, `ie_udre`, `ie_txc`), `gie` and its flag (`rx_avail`, `tx_empty`, `tx_done`) are all 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| mpcm_en | input | 1 | Address-filtering mode |
| data_bits | input | 4 | Character length, 5 to 9 |
| parity_mode | input | 2 | 10 even, 11 odd, 0x none |
| baud_div | input | DIV_W | Tick divider, a tick every baud_div+1 clocks |
| rx_in | input | 1 | Serial line, idle high |
| rd_stb | input | 1 | Pop the oldest character |
| rd_data | output | 9 | Oldest character, right-aligned |
| rd_fe | output | 1 | Frame error of oldest character |
| rd_pe | output | 1 | Parity error of oldest character |
| rd_dor | output | 1 | Data-lost flag of oldest character |
| rx_avail | output | 1 | At least one unread character |
| gie | input | 1 | Global interrupt enable |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_udre | input | 1 | Transmit-buffer-empty interrupt enable |
| ie_txc | input | 1 | Transmit-done interrupt enable |
| tx_empty | input | 1 | Transmit buffer empty flag from the transmitter |
| tx_done | input | 1 | Transmit complete flag from the transmitter |
| irq_rxc | output | 1 | Receive-complete request |
| irq_udre | output | 1 | Transmit-buffer-empty request |
| irq_txc | output | 1 | Transmit-done request |

## Verification
The read pop and the transfer of the waiting character into the freed entry can fall in the same clock. At that moment the buffer does a push and a pop together while the holding register empties. The bench provokes this by sending four characters without reading, so the fourth start bit sets the data-lost state. It then pops the buffer one entry at a time. It judges the result by the order of the characters that come out and by `rd_dor`, which must be set only on the character that replaced the lost one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAXB = 9;
  localparam int MINB = 5;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef struct packed {
    logic [MAXB-1:0] data;
    logic            fe;
    logic            pe;
    logic            dor;
  } rx_entry_t;

  function automatic logic [3:0] clamp_bits(input logic [3:0] b);
    if (b < 4'(MINB)) return 4'(MINB);
    else if (b > 4'(MAXB)) return 4'(MAXB);
    else return b;
  endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            rx_in,
  input  logic            dbl,
  input  logic [3:0]      nbits,
  input  logic [1:0]      par_mode,
  output logic            start_det,
  output logic            chr_vld,
  output logic [MAXB-1:0] chr_data,
  output logic            chr_fe,
  output logic            chr_pe,
  output logic            chr_mark
);

  localparam int SW = $clog2(OS_NORM);
  localparam logic [SW-1:0] LAST_N = SW'(OS_NORM - 1);
  localparam logic [SW-1:0] LAST_F = SW'(OS_FAST - 1);
  localparam logic [SW-1:0] VOTE_N = SW'(OS_NORM / 2 - 1);
  localparam logic [SW-1:0] VOTE_F = SW'(OS_FAST / 2);

  logic            rx_m, rx_s;
  fr_state_t       st;
  logic [SW-1:0]   smp;
  logic [3:0]      bcnt, c_nb;
  logic [1:0]      c_par;
  logic            c_dbl;
  logic [MAXB-1:0] shreg;
  logic            v0, v1, par_bit, idle_hi;
  logic [SW-1:0]   last, vlo;
  logic            maj;

  // two-flop synchronizer, idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  always_comb begin
    last = c_dbl ? LAST_F : LAST_N;
    vlo  = c_dbl ? VOTE_F : VOTE_N;
    maj  = (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st        <= FR_IDLE;
      smp       <= '0;
      bcnt      <= '0;
      c_nb      <= 4'(MAXB);
      c_par     <= 2'b00;
      c_dbl     <= 1'b0;
      shreg     <= '0;
      v0        <= 1'b1;
      v1        <= 1'b1;
      par_bit   <= 1'b0;
      idle_hi   <= 1'b0;
      start_det <= 1'b0;
      chr_vld   <= 1'b0;
      chr_data  <= '0;
      chr_fe    <= 1'b0;
      chr_pe    <= 1'b0;
      chr_mark  <= 1'b0;
    end else begin
      start_det <= 1'b0;
      chr_vld   <= 1'b0;
      if (tick) begin
        if (st == FR_IDLE) begin
          if (rx_s) begin
            idle_hi <= 1'b1;
          end else if (idle_hi) begin
            st        <= FR_START;
            smp       <= SW'(1);
            bcnt      <= '0;
            shreg     <= '0;
            c_nb      <= clamp_bits(nbits);
            c_par     <= par_mode;
            c_dbl     <= dbl;
            idle_hi   <= 1'b0;
            start_det <= 1'b1;
          end
        end else begin
          smp <= (smp == last) ? '0 : smp + 1'b1;
          if (smp == vlo)        v0 <= rx_s;
          if (smp == vlo + 1'b1) v1 <= rx_s;
          if (smp == vlo + 2'd2) begin
            unique case (st)
              FR_START: if (maj) st <= FR_IDLE;
              FR_DATA: begin
                shreg <= {maj, shreg[MAXB-1:1]};
                bcnt  <= bcnt + 1'b1;
              end
              FR_PAR: par_bit <= maj;
              FR_STOP: begin
                chr_vld  <= 1'b1;
                chr_fe   <= ~maj;
                chr_pe   <= c_par[1] && (par_bit != ((^shreg) ^ c_par[0]));
                chr_data <= shreg >> (4'(MAXB) - c_nb);
                chr_mark <= shreg[MAXB-1];
                st       <= FR_IDLE;
              end
              default: st <= FR_IDLE;
            endcase
          end
          if (smp == last) begin
            unique case (st)
              FR_START: st <= FR_DATA;
              FR_DATA:  if (bcnt == c_nb) st <= c_par[1] ? FR_PAR : FR_STOP;
              FR_PAR:   st <= FR_STOP;
              default:  st <= st;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t wdata,
  input  logic      pop,
  output rx_entry_t head,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic            do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);
  assign head    = mem[rp];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int DEPTH   = 2,
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             dbl_speed,
  input  logic             mpcm_en,
  input  logic [3:0]       data_bits,
  input  logic [1:0]       parity_mode,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rx_in,
  input  logic             rd_stb,
  output logic [MAXB-1:0]  rd_data,
  output logic             rd_fe,
  output logic             rd_pe,
  output logic             rd_dor,
  output logic             rx_avail,
  input  logic             gie,
  input  logic             ie_rxc,
  input  logic             ie_udre,
  input  logic             ie_txc,
  input  logic             tx_empty,
  input  logic             tx_done,
  output logic             irq_rxc,
  output logic             irq_udre,
  output logic             irq_txc
);

  localparam int CW = $clog2(DEPTH + 1);

  logic            tick;
  logic            start_det, chr_vld, chr_fe, chr_pe, chr_mark;
  logic [MAXB-1:0] chr_data;
  logic [CW-1:0]   fcnt;
  rx_entry_t       head, wdata, pend, new_ent;
  logic            pend_v, dor_arm;
  logic            fifo_full, pop, space, chr_ok, push;

  uart_rx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst(rst), .en(rx_en), .div(baud_div), .tick(tick)
  );

  uart_rx_framer #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) i_framer (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rx_in(rx_in),
    .dbl(dbl_speed), .nbits(data_bits), .par_mode(parity_mode),
    .start_det(start_det), .chr_vld(chr_vld), .chr_data(chr_data),
    .chr_fe(chr_fe), .chr_pe(chr_pe), .chr_mark(chr_mark)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .flush(!rx_en), .push(push), .wdata(wdata),
    .pop(pop), .head(head), .cnt(fcnt)
  );

  assign rx_avail  = (fcnt != '0);
  assign fifo_full = (fcnt == CW'(DEPTH));
  assign pop       = rd_stb && rx_avail;
  assign space     = !fifo_full || pop;
  assign chr_ok    = chr_vld && (!mpcm_en || chr_mark);

  assign rd_data = head.data;
  assign rd_fe   = head.fe;
  assign rd_pe   = head.pe;
  assign rd_dor  = head.dor;

  always_comb begin
    new_ent = '{data: chr_data, fe: chr_fe, pe: chr_pe, dor: dor_arm};
    push    = 1'b0;
    wdata   = pend;
    if (pend_v && space) begin
      push  = 1'b1;
      wdata = pend;
    end else if (!pend_v && chr_ok && space) begin
      push  = 1'b1;
      wdata = new_ent;
    end
  end

  // holding register for a finished character that finds the buffer full
  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      pend_v  <= 1'b0;
      pend    <= '0;
      dor_arm <= 1'b0;
    end else begin
      if (start_det && pend_v && fifo_full && !pop) dor_arm <= 1'b1;
      if (chr_ok) begin
        dor_arm <= 1'b0;
        if (pend_v || !space) begin
          pend   <= new_ent;
          pend_v <= 1'b1;
        end
      end else if (pend_v && space) begin
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rxc  <= 1'b0;
      irq_udre <= 1'b0;
      irq_txc  <= 1'b0;
    end else begin
      irq_rxc  <= ie_rxc  && gie && rx_avail;
      irq_udre <= ie_udre && gie && tx_empty;
      irq_txc  <= ie_txc  && gie && tx_done;
    end
  end

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DEPTH = 2
) (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic rd_stb,
  input logic rx_avail,
  input logic gie,
  input logic ie_rxc,
  input logic ie_udre,
  input logic ie_txc,
  input logic tx_empty,
  input logic tx_done,
  input logic irq_rxc,
  input logic irq_udre,
  input logic irq_txc,
  input logic [$clog2(DEPTH+1)-1:0] fcnt
);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    fcnt <= ($clog2(DEPTH+1))'(DEPTH));

  assert_hold_unread_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_avail && !rd_stb) |=> rx_avail);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_avail);

  assert_fill_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_avail) |-> $past(rx_en));

  assert_rxc_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_rxc |-> $past(ie_rxc && gie && rx_avail));

  assert_udre_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_udre |-> $past(ie_udre && gie && tx_empty));

  assert_txc_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_txc |-> $past(ie_txc && gie && tx_done));

endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_stb(rd_stb), .rx_avail(rx_avail),
  .gie(gie), .ie_rxc(ie_rxc), .ie_udre(ie_udre), .ie_txc(ie_txc),
  .tx_empty(tx_empty), .tx_done(tx_done), .irq_rxc(irq_rxc),
  .irq_udre(irq_udre), .irq_txc(irq_txc), .fcnt(fcnt)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;

  localparam int BDIV = 1;
  localparam int NV   = 10;

  typedef struct packed {
    logic [3:0] nb;
    logic [1:0] pm;
    logic       dbl;
    logic [8:0] d;
    logic       stp;
    logic       flip;
    logic [8:0] ed;
    logic       efe;
    logic       epe;
  } vec_t;

  // nb, parity mode, double speed, data, stop level, flip parity, exp data, exp fe, exp pe
  localparam vec_t VECS [NV] = '{
    '{4'd8, 2'b00, 1'b0, 9'h0A5, 1'b1, 1'b0, 9'h0A5, 1'b0, 1'b0},
    '{4'd5, 2'b00, 1'b0, 9'h015, 1'b1, 1'b0, 9'h015, 1'b0, 1'b0},
    '{4'd9, 2'b00, 1'b0, 9'h1C3, 1'b1, 1'b0, 9'h1C3, 1'b0, 1'b0},
    '{4'd7, 2'b10, 1'b0, 9'h05A, 1'b1, 1'b0, 9'h05A, 1'b0, 1'b0},
    '{4'd7, 2'b11, 1'b0, 9'h05A, 1'b1, 1'b1, 9'h05A, 1'b0, 1'b1},
    '{4'd8, 2'b10, 1'b1, 9'h0F0, 1'b1, 1'b1, 9'h0F0, 1'b0, 1'b1},
    '{4'd6, 2'b00, 1'b1, 9'h02D, 1'b0, 1'b0, 9'h02D, 1'b1, 1'b0},
    '{4'd9, 2'b11, 1'b1, 9'h101, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0},
    '{4'd8, 2'b01, 1'b0, 9'h033, 1'b1, 1'b1, 9'h033, 1'b0, 1'b0},
    '{4'd8, 2'b00, 1'b0, 9'h000, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, dbl_speed = 1'b0, mpcm_en = 1'b0;
  logic [3:0] data_bits = 4'd8;
  logic [1:0] parity_mode = 2'b00;
  logic [11:0] baud_div = 12'(BDIV);
  logic       rx_in = 1'b1, rd_stb = 1'b0;
  logic [8:0] rd_data;
  logic       rd_fe, rd_pe, rd_dor, rx_avail;
  logic       gie = 1'b0, ie_rxc = 1'b0, ie_udre = 1'b0, ie_txc = 1'b0;
  logic       tx_empty = 1'b0, tx_done = 1'b0;
  logic       irq_rxc, irq_udre, irq_txc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst(rst), .rx_en(rx_en), .dbl_speed(dbl_speed), .mpcm_en(mpcm_en),
    .data_bits(data_bits), .parity_mode(parity_mode), .baud_div(baud_div),
    .rx_in(rx_in), .rd_stb(rd_stb), .rd_data(rd_data), .rd_fe(rd_fe),
    .rd_pe(rd_pe), .rd_dor(rd_dor), .rx_avail(rx_avail), .gie(gie),
    .ie_rxc(ie_rxc), .ie_udre(ie_udre), .ie_txc(ie_txc), .tx_empty(tx_empty),
    .tx_done(tx_done), .irq_rxc(irq_rxc), .irq_udre(irq_udre), .irq_txc(irq_txc)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] nb, input logic [1:0] pm, input logic dbl,
                      input logic [8:0] d, input logic stp, input logic flip);
    int  bt;
    logic p;
    bt = (dbl ? 8 : 16) * (BDIV + 1);
    p  = 1'b0;
    for (int i = 0; i < int'(nb); i++) p ^= d[i];
    if (pm[0]) p = ~p;
    p ^= flip;
    @(negedge clk);
    data_bits = nb; parity_mode = pm; dbl_speed = dbl;
    rx_in = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < int'(nb); i++) begin
      rx_in = d[i];
      repeat (bt) @(negedge clk);
    end
    if (pm[1]) begin
      rx_in = p;
      repeat (bt) @(negedge clk);
    end
    rx_in = stp;
    repeat (bt) @(negedge clk);
    rx_in = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic pop_one();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R6 reset avail", 16'(rx_avail), 16'h0);
    chk("R10 reset irq", 16'({irq_rxc, irq_udre, irq_txc}), 16'h0);
    rx_en = 1'b1;
    repeat (40) @(negedge clk);

    // table walk: R1 R2 R4 R5
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].nb, VECS[v].pm, VECS[v].dbl, VECS[v].d, VECS[v].stp, VECS[v].flip);
      chk($sformatf("R1 R2 vec%0d avail", v), 16'(rx_avail), 16'h1);
      chk($sformatf("R1 vec%0d data", v), 16'(rd_data), 16'(VECS[v].ed));
      chk($sformatf("R4 vec%0d fe", v), 16'(rd_fe), 16'(VECS[v].efe));
      chk($sformatf("R5 vec%0d pe", v), 16'(rd_pe), 16'(VECS[v].epe));
      pop_one();
      chk($sformatf("R6 vec%0d empty after pop", v), 16'(rx_avail), 16'h0);
    end

    // R3: short low glitch gives nothing
    @(negedge clk);
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (80) @(negedge clk);
    chk("R3 glitch rejected", 16'(rx_avail), 16'h0);

    // R6: two characters kept in order with own flags
    send(4'd8, 2'b00, 1'b0, 9'h03C, 1'b0, 1'b0);
    send(4'd8, 2'b00, 1'b0, 9'h0C3, 1'b1, 1'b0);
    chk("R6 first data", 16'(rd_data), 16'h03C);
    chk("R6 first fe", 16'(rd_fe), 16'h1);
    pop_one();
    chk("R6 second data", 16'(rd_data), 16'h0C3);
    chk("R6 second fe", 16'(rd_fe), 16'h0);
    pop_one();
    chk("R6 drained", 16'(rx_avail), 16'h0);

    // R7: four characters without reading, third is lost
    send(4'd8, 2'b00, 1'b0, 9'h011, 1'b1, 1'b0);
    send(4'd8, 2'b00, 1'b0, 9'h022, 1'b1, 1'b0);
    send(4'd8, 2'b00, 1'b0, 9'h033, 1'b1, 1'b0);
    send(4'd8, 2'b00, 1'b0, 9'h044, 1'b1, 1'b0);
    chk("R7 head data", 16'(rd_data), 16'h011);
    chk("R7 head dor", 16'(rd_dor), 16'h0);
    pop_one();
    chk("R7 second data", 16'(rd_data), 16'h022);
    chk("R7 second dor", 16'(rd_dor), 16'h0);
    pop_one();
    chk("R7 replacement data", 16'(rd_data), 16'h044);
    chk("R7 replacement dor", 16'(rd_dor), 16'h1);
    pop_one();
    chk("R7 drained", 16'(rx_avail), 16'h0);

    // R8: address filtering
    mpcm_en = 1'b1;
    send(4'd9, 2'b00, 1'b0, 9'h055, 1'b1, 1'b0);
    chk("R8 unmarked dropped", 16'(rx_avail), 16'h0);
    send(4'd9, 2'b00, 1'b0, 9'h1A5, 1'b1, 1'b0);
    chk("R8 marked kept", 16'(rx_avail), 16'h1);
    chk("R8 marked data", 16'(rd_data), 16'h1A5);
    pop_one();
    mpcm_en = 1'b0;

    // R10: interrupt gating
    send(4'd8, 2'b00, 1'b0, 9'h077, 1'b1, 1'b0);
    ie_rxc = 1'b1;
    @(negedge clk);
    chk("R10 rxc without gie", 16'(irq_rxc), 16'h0);
    gie = 1'b1;
    @(negedge clk);
    chk("R10 rxc raised", 16'(irq_rxc), 16'h1);
    tx_empty = 1'b1;
    @(negedge clk);
    chk("R10 udre without enable", 16'(irq_udre), 16'h0);
    ie_udre = 1'b1;
    tx_done = 1'b1;
    @(negedge clk);
    chk("R10 udre raised", 16'(irq_udre), 16'h1);
    chk("R10 txc without enable", 16'(irq_txc), 16'h0);
    ie_txc = 1'b1;
    @(negedge clk);
    chk("R10 txc raised", 16'(irq_txc), 16'h1);
    gie = 1'b0;
    @(negedge clk);
    chk("R10 all dropped", 16'({irq_rxc, irq_udre, irq_txc}), 16'h0);

    // R9: disabling flushes the buffer
    send(4'd8, 2'b00, 1'b0, 9'h088, 1'b1, 1'b0);
    chk("R9 filled", 16'(rx_avail), 16'h1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R9 flushed", 16'(rx_avail), 16'h0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 stays empty", 16'(rx_avail), 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule